// File: doc/BRIEF.md
# Binary-tree ID enumerator for a single-wire bus

This block is the master side of the device discovery procedure on a single-wire bus. It does not time any bus slot itself. It drives a lower slot engine through a request/acknowledge pair, and every request names one of three operations: bus reset, write one bit, or read one bit. Each pass opens with a reset and a presence check. The block then writes a command byte: one value enumerates every device, the other enumerates only devices whose alarm condition is set. After the command, the block walks all ID positions in turn. At each position it reads the bit and its inverse, chooses a branch, and writes that branch back to the bus.

From pass to pass the block remembers the highest position where it chose the 0 branch at a conflict. The next pass uses this to take the other branch, so successive passes walk the whole device tree and report one device ID per pass. A flag shows that the last device has been reported. The block also raises a flag when no device answers.

Top module: `owsrch_master`

## Requirements
- R1: After `start`, the first request is a bus reset (op_code 0). It is followed by eight write requests (op_code 1) that carry the command 0xF0, least significant bit first.
- R2: If `alarm_only` is high at `start`, the command is 0xEC. Only devices with their alarm set then take part in the pass.
- R3: After the command, each of the ID_W positions (bit 0 first) uses exactly two read requests (op_code 2) followed by one write request. A full pass is 1 reset, 8+ID_W writes and 2·ID_W reads.
- R4: If the reset acknowledge returns `op_rbit`=0 (no presence), the pass ends with `no_dev` high and no `id_valid`.
- R5: A read pair of 1,1 at any position ends the pass with `no_dev` high and no `id_valid`.
- R6: Where a read pair is 0,0, the block makes one of three choices. Below the previous pass's last 0-branch position it repeats that pass's bit. At that position it takes 1. Above it, it takes 0. As a result, successive passes report every device exactly once, in ascending order of the ID read with bit 0 as the most significant bit.
- R7: `id_out` holds the bits written during the pass, assembled with bit 0 as the first position. It equals the ID of the device that stayed in the search.
- R8: `done` rises together with the `id_valid` of the pass that took no 0 branch at a conflict. The following `start` begins the walk again from the first device.
- R9: `id_valid` is high for exactly one cycle per successful pass.
- R10: `op_req` is low while the block is idle. While a request waits for `op_ack`, `op_req` and `op_code` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (sampled while idle) |
| alarm_only | input | 1 | Enumerate only alarmed devices this pass |
| op_req | output | 1 | Request to the slot engine |
| op_code | output | 2 | 0 reset, 1 write bit, 2 read bit |
| op_wbit | output | 1 | Bit to write for op_code 1 |
| op_ack | input | 1 | One-cycle completion from the slot engine |
| op_rbit | input | 1 | Read result, or presence (1) for a reset |
| id_out | output | ID_W | ID found in the last successful pass |
| id_valid | output | 1 | One-cycle strobe when id_out updates |
| done | output | 1 | Last device has been reported |
| no_dev | output | 1 | Pass ended with no responding device |
| busy | output | 1 | A pass is in progress |

## Verification
The bench models a set of devices with wired-AND reads. It sweeps device sets built so that IDs share long common prefixes and split at both low and high positions. The expected order comes from sorting the bit-reversed IDs. A design that gets the "at the last position take 1" rule wrong either repeats a device forever or skips part of the tree, and the bench sees this as an ID out of order or a missing `done`. A design that ignores the 1,1 pair under the alarm command reports an all-ones ID instead of raising `no_dev`. If the walk is not restarted after `done`, the next pass reports the wrong device. Slot and command-bit counts catch a missing or extra read, and a command sent most significant bit first.

// File: rtl/owsrch_pkg.sv
package owsrch_pkg;
   typedef enum logic [1:0] {
      OP_RST = 2'd0,
      OP_WR  = 2'd1,
      OP_RD  = 2'd2
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_CMD,
      ST_RDT,
      ST_RDC,
      ST_WRD,
      ST_FIN
   } st_e;
endpackage

// File: rtl/owsrch_dirsel.sv
// Branch choice for one ID position from the read pair and the walk state.
module owsrch_dirsel #(
   parameter int PW = 7
) (
   input  logic          rd_t,
   input  logic          rd_c,
   input  logic [PW-1:0] pos_n,      // 1-based position
   input  logic [PW-1:0] last_disc,  // 0 = none
   input  logic          prev_bit,
   output logic          dir,
   output logic          absent,
   output logic          fork_zero
);
   logic fork_pt;

   always_comb begin
      absent  = rd_t & rd_c;
      fork_pt = ~rd_t & ~rd_c;
      if (fork_pt) begin
         if (pos_n < last_disc)       dir = prev_bit;
         else if (pos_n == last_disc) dir = 1'b1;
         else                         dir = 1'b0;
      end else begin
         dir = rd_t;
      end
      fork_zero = fork_pt & ~dir;
   end
endmodule

// File: rtl/owsrch_idreg.sv
// Working ID register: bit p keeps the previous pass value until rewritten.
module owsrch_idreg #(
   parameter int ID_W = 64,
   localparam int IW = $clog2(ID_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IW-1:0]   wr_idx,
   input  logic            wr_bit,
   input  logic [IW-1:0]   rd_idx,
   output logic            rd_bit,
   output logic [ID_W-1:0] id_q
);
   for (genvar g = 0; g < ID_W; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              id_q[g] <= 1'b0;
         else if (wr_en && wr_idx == IW'(g))      id_q[g] <= wr_bit;
      end
   end

   assign rd_bit = id_q[rd_idx];
endmodule

// File: rtl/owsrch_master.sv
module owsrch_master
   import owsrch_pkg::*;
#(
   parameter int         ID_W    = 64,
   parameter logic [7:0] CMD_ALL = 8'hF0,
   parameter logic [7:0] CMD_ALM = 8'hEC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            alarm_only,
   output logic            op_req,
   output logic [1:0]      op_code,
   output logic            op_wbit,
   input  logic            op_ack,
   input  logic            op_rbit,
   output logic [ID_W-1:0] id_out,
   output logic            id_valid,
   output logic            done,
   output logic            no_dev,
   output logic            busy
);
   localparam int PW = $clog2(ID_W + 1);
   localparam int IW = $clog2(ID_W);

   if (ID_W < 8) begin : g_chk_w
      $error("ID_W must be at least 8");
   end
   if (CMD_ALL == CMD_ALM) begin : g_chk_cmd
      $error("command values must differ");
   end

   st_e           st;
   logic [IW-1:0] cnt;
   logic          alm_q;
   logic          rd_t_q;
   logic          dir_q;
   logic [PW-1:0] last_disc;
   logic [PW-1:0] last_zero;
   logic [7:0]    cmd_byte;
   logic [PW-1:0] pos_n;
   logic          prev_bit;
   logic          dir_w;
   logic          absent_w;
   logic          fzero_w;
   logic [ID_W-1:0] work_id;
   logic          last_pos;

   assign cmd_byte = alm_q ? CMD_ALM : CMD_ALL;
   assign pos_n    = PW'(cnt) + PW'(1);
   assign last_pos = (cnt == IW'(ID_W - 1));
   assign busy     = (st != ST_IDLE);

   always_comb begin
      op_req  = 1'b1;
      op_code = OP_RD;
      op_wbit = 1'b0;
      unique case (st)
         ST_RST:  op_code = OP_RST;
         ST_CMD:  begin op_code = OP_WR; op_wbit = cmd_byte[cnt[2:0]]; end
         ST_RDT,
         ST_RDC:  op_code = OP_RD;
         ST_WRD:  begin op_code = OP_WR; op_wbit = dir_q; end
         default: op_req = 1'b0;
      endcase
   end

   owsrch_dirsel #(.PW(PW)) dirsel_i (
      .rd_t      (rd_t_q),
      .rd_c      (op_rbit),
      .pos_n     (pos_n),
      .last_disc (last_disc),
      .prev_bit  (prev_bit),
      .dir       (dir_w),
      .absent    (absent_w),
      .fork_zero (fzero_w)
   );

   owsrch_idreg #(.ID_W(ID_W)) idreg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (st == ST_WRD && op_ack),
      .wr_idx (cnt),
      .wr_bit (dir_q),
      .rd_idx (cnt),
      .rd_bit (prev_bit),
      .id_q   (work_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         alm_q     <= 1'b0;
         rd_t_q    <= 1'b0;
         dir_q     <= 1'b0;
         last_disc <= '0;
         last_zero <= '0;
         id_out    <= '0;
         id_valid  <= 1'b0;
         done      <= 1'b0;
         no_dev    <= 1'b0;
      end else begin
         id_valid <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               alm_q     <= alarm_only;
               done      <= 1'b0;
               no_dev    <= 1'b0;
               last_zero <= '0;
               cnt       <= '0;
               st        <= ST_RST;
            end
            ST_RST: if (op_ack) begin
               if (!op_rbit) begin
                  no_dev    <= 1'b1;
                  last_disc <= '0;
                  st        <= ST_IDLE;
               end else begin
                  cnt <= '0;
                  st  <= ST_CMD;
               end
            end
            ST_CMD: if (op_ack) begin
               if (cnt == IW'(7)) begin
                  cnt <= '0;
                  st  <= ST_RDT;
               end else begin
                  cnt <= cnt + IW'(1);
               end
            end
            ST_RDT: if (op_ack) begin
               rd_t_q <= op_rbit;
               st     <= ST_RDC;
            end
            ST_RDC: if (op_ack) begin
               if (absent_w) begin
                  no_dev    <= 1'b1;
                  last_disc <= '0;
                  st        <= ST_IDLE;
               end else begin
                  dir_q <= dir_w;
                  if (fzero_w) last_zero <= pos_n;
                  st <= ST_WRD;
               end
            end
            ST_WRD: if (op_ack) begin
               if (last_pos) st <= ST_FIN;
               else begin
                  cnt <= cnt + IW'(1);
                  st  <= ST_RDT;
               end
            end
            ST_FIN: begin
               id_out    <= work_id;
               id_valid  <= 1'b1;
               last_disc <= last_zero;
               done      <= (last_zero == '0);
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/owsrch_master_chk.sv
module owsrch_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       op_req,
   input logic [1:0] op_code,
   input logic       op_ack,
   input logic       id_valid,
   input logic       done,
   input logic       no_dev,
   input logic       busy
);
   a_r9_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |=> !id_valid);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !op_req);

   a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req && !op_ack) |=> (op_req && $stable(op_code)));

   a_r4_no_id_when_absent: assert property (@(posedge clk) disable iff (!rst_n)
      !(id_valid && no_dev));

   a_r8_done_with_id: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> id_valid);

   a_r1_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (op_req && op_code == 2'd0));
endmodule

bind owsrch_master owsrch_master_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_req   (op_req),
   .op_code  (op_code),
   .op_ack   (op_ack),
   .id_valid (id_valid),
   .done     (done),
   .no_dev   (no_dev),
   .busy     (busy)
);

// File: tb/owsrch_master_tb_top.sv
`timescale 1ns/1ps
module owsrch_master_tb_top;
   localparam int W    = 64;
   localparam int MAXD = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic alarm_only = 1'b0;
   logic op_req;
   logic [1:0] op_code;
   logic op_wbit;
   logic op_ack = 1'b0;
   logic op_rbit = 1'b0;
   logic [W-1:0] id_out;
   logic id_valid, done, no_dev, busy;

   always #2 clk = ~clk;

   owsrch_master #(.ID_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .alarm_only(alarm_only),
      .op_req(op_req), .op_code(op_code), .op_wbit(op_wbit),
      .op_ack(op_ack), .op_rbit(op_rbit),
      .id_out(id_out), .id_valid(id_valid), .done(done),
      .no_dev(no_dev), .busy(busy)
   );

   int tests = 0;
   int fails = 0;

   // device model state
   logic [W-1:0] dev_id [MAXD];
   logic         dev_alm [MAXD];
   logic         dev_act [MAXD];
   int           ndev = 0;
   int           n_rst, n_wr, n_rd, wcnt, pos, hold_err;
   logic [7:0]   cmd_seen;
   logic         phase;

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reactive slot-engine plus device model, acknowledges after two waiting cycles
   initial begin
      int wait_c = 0;
      logic [1:0] code_q = 2'd0;
      forever begin
         @(negedge clk);
         op_ack = 1'b0;
         if (op_req) begin
            if (wait_c > 0 && op_code != code_q) hold_err++;
            code_q = op_code;
            wait_c++;
            if (wait_c == 3) begin
               wait_c = 0;
               op_ack = 1'b1;
               case (op_code)
                  2'd0: begin
                     n_rst++;
                     for (int i = 0; i < MAXD; i++) dev_act[i] = (i < ndev);
                     op_rbit = (ndev > 0);
                     wcnt = 0; pos = 0; phase = 1'b0; cmd_seen = 8'h00;
                  end
                  2'd1: begin
                     n_wr++;
                     if (wcnt < 8) begin
                        cmd_seen[wcnt] = op_wbit;
                        wcnt++;
                        if (wcnt == 8 && cmd_seen == 8'hEC)
                           for (int i = 0; i < MAXD; i++) dev_act[i] = dev_act[i] & dev_alm[i];
                     end else begin
                        for (int i = 0; i < MAXD; i++)
                           if (dev_act[i] && dev_id[i][pos] != op_wbit) dev_act[i] = 1'b0;
                        pos++;
                     end
                  end
                  default: begin
                     logic b;
                     n_rd++;
                     b = 1'b1;
                     for (int i = 0; i < MAXD; i++)
                        if (dev_act[i]) b = b & (phase ? ~dev_id[i][pos % W] : dev_id[i][pos % W]);
                     op_rbit = b;
                     phase = ~phase;
                  end
               endcase
            end
         end else begin
            wait_c = 0;
         end
      end
   end

   function automatic logic [W-1:0] rev(input logic [W-1:0] x);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = x[W-1-i];
      return r;
   endfunction

   // expected enumeration order: ascending bit-reversed value of participants
   logic [W-1:0] exp_ord [MAXD];
   int           nexp;

   task automatic build_expect(input bit alm);
      nexp = 0;
      for (int i = 0; i < ndev; i++)
         if (!alm || dev_alm[i]) begin exp_ord[nexp] = dev_id[i]; nexp++; end
      for (int i = 0; i < nexp; i++)
         for (int j = i + 1; j < nexp; j++)
            if (rev(exp_ord[j]) < rev(exp_ord[i])) begin
               logic [W-1:0] t;
               t = exp_ord[i]; exp_ord[i] = exp_ord[j]; exp_ord[j] = t;
            end
   endtask

   task automatic run_pass(input bit alm, output bit got, output logic [W-1:0] id,
                           output bit dn, output bit nd);
      n_rst = 0; n_wr = 0; n_rd = 0;
      @(negedge clk);
      alarm_only = alm;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!id_valid && !no_dev) @(negedge clk);
      got = id_valid; id = id_out; dn = done; nd = no_dev;
      @(negedge clk);
      if (got) chk(id_valid == 1'b0, "R9 strobe width", W'(id_valid), '0);
   endtask

   task automatic sweep(input bit alm, input string tag);
      bit got, dn, nd;
      logic [W-1:0] id;
      build_expect(alm);
      for (int k = 0; k < nexp; k++) begin
         run_pass(alm, got, id, dn, nd);
         chk(got && !nd, {"R6 pass produced ID ", tag}, W'(got), 1);
         chk(id == exp_ord[k], {"R6 R7 order/ID ", tag}, id, exp_ord[k]);
         chk(dn == (k == nexp - 1), {"R8 done ", tag}, W'(dn), W'(k == nexp - 1));
         chk(n_rst == 1 && n_rd == 2 * W && n_wr == 8 + W, {"R3 slot counts ", tag},
             W'(n_rd), W'(2 * W));
         chk(cmd_seen == (alm ? 8'hEC : 8'hF0), alm ? "R2 alarm command" : "R1 command LSB first",
             W'(cmd_seen), W'(alm ? 8'hEC : 8'hF0));
      end
      // R8: restart after done gives the first device again
      run_pass(alm, got, id, dn, nd);
      chk(got && id == exp_ord[0], {"R8 restart ", tag}, id, exp_ord[0]);
   endtask

   initial begin
      #600000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      bit got, dn, nd;
      logic [W-1:0] id;
      hold_err = 0;
      for (int i = 0; i < MAXD; i++) begin dev_id[i] = '0; dev_alm[i] = 1'b0; dev_act[i] = 1'b0; end
      repeat (3) @(negedge clk);
      chk(!busy && !op_req && !id_valid && !done && !no_dev, "R10 reset state idle",
          W'({busy, op_req, id_valid, done, no_dev}), '0);
      rst_n = 1'b1;
      @(negedge clk);

      // single device
      ndev = 1; dev_id[0] = 64'hA55A_0F0F_3C3C_9001;
      sweep(1'b0, "one device");

      // four devices with shared prefixes, splits low and high
      ndev = 4;
      dev_id[0] = 64'h0000_0000_0000_0010;
      dev_id[1] = 64'h8000_0000_0000_0010;
      dev_id[2] = 64'h0000_0000_0000_0011;
      dev_id[3] = 64'h8000_0000_0000_0013;
      sweep(1'b0, "four devices");

      // eight devices, arithmetic spread
      ndev = 8;
      for (int i = 0; i < 8; i++)
         dev_id[i] = (64'h9E37_79B9_7F4A_7C15 * 64'(i + 3)) ^ 64'(i << 60);
      sweep(1'b0, "eight devices");

      // alarm filter: two of five alarmed
      ndev = 5;
      for (int i = 0; i < 5; i++) begin
         dev_id[i]  = 64'h0123_4567_89AB_CDEF + 64'(i * 7);
         dev_alm[i] = (i == 1 || i == 4);
      end
      sweep(1'b1, "alarm subset");

      // alarm command with nobody alarmed: 1,1 pair
      for (int i = 0; i < MAXD; i++) dev_alm[i] = 1'b0;
      run_pass(1'b1, got, id, dn, nd);
      chk(nd && !got, "R5 no alarmed device", W'(nd), 1);

      // no device on the bus: no presence
      ndev = 0;
      run_pass(1'b0, got, id, dn, nd);
      chk(nd && !got, "R4 no presence", W'(nd), 1);
      chk(n_rd == 0 && n_wr == 0, "R4 pass stops after reset", W'(n_rd + n_wr), 0);

      // recovery after a failed pass
      ndev = 2;
      dev_id[0] = 64'h0000_0000_0000_0002;
      dev_id[1] = 64'h0000_0000_0000_0001;
      sweep(1'b0, "after no_dev");

      chk(hold_err == 0, "R10 op_code held while waiting", W'(hold_err), 0);
      repeat (4) @(negedge clk);
      chk(!busy && !op_req, "R10 idle after passes", W'(op_req), 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule